// File: doc/BRIEF.md
# Flash Supply Warm-up Controller

This block owns the supply switch of a flash memory control circuit and tells software when that supply can be trusted again. Software writes a single power bit. Writing zero cuts the supply at once. Writing one while the supply is off switches it back on and starts a settling count. The count advances on one of two clock-enable ticks: the fast tick when the high-frequency clock drives the system, the slow tick when the low-frequency clock does. When the count ends, a ready flag rises and stays up.

The processor is never stalled. Software polls the ready flag, and the block drives an access-grant output that is high only when the supply is on and settled. A flash request made while the grant is low produces a one-cycle violation pulse, so a downstream monitor can trap early accesses. At reset the supply is on and already settled, so boot code can fetch from flash at once.

Top module: `flash_pwr_warmup`

## Requirements
- R1: After reset, `pwr_en`, `wu_done` and `access_ok` are 1 and `req_violation` is 0.
- R2: A write with `cfg_wdata` = 0 makes `pwr_en` and `wu_done` 0 on the next cycle, from any state.
- R3: A write with `cfg_wdata` = 1 while `pwr_en` is 0 makes `pwr_en` 1 and keeps `wu_done` 0 on the next cycle, and starts a warm-up count from zero.
- R4: When `clk_sel` was 0 at the start write, `wu_done` becomes 1 in the cycle after the 2^FAST_LOG2-th cycle with `tick_fast` high (1024 by default). `tick_slow` has no effect.
- R5: When `clk_sel` was 1 at the start write, `wu_done` becomes 1 in the cycle after the 2^SLOW_LOG2-th cycle with `tick_slow` high (8 by default). `tick_fast` has no effect.
- R6: `clk_sel` is sampled only in the start cycle. Changing it during warm-up does not change the tick source or the length.
- R7: A write with `cfg_wdata` = 1 while `pwr_en` is 1 has no effect. It neither restarts the count nor clears `wu_done`.
- R8: A write of 0 during warm-up aborts it. The next start needs the full count again.
- R9: `access_ok` is 1 exactly when `pwr_en` and `wu_done` are both 1.
- R10: `req_violation` is 1 for one cycle after a cycle in which `flash_req` was 1 while `access_ok` was 0, and is 0 otherwise.
- R11: A write of 0 in the same cycle as the final counting tick wins. The supply goes off and `wu_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the power bit |
| cfg_wdata | input | 1 | Power bit value to write |
| tick_fast | input | 1 | Clock-enable tick of the high-frequency clock |
| tick_slow | input | 1 | Clock-enable tick of the low-frequency clock |
| clk_sel | input | 1 | Active system clock: 0 high-frequency, 1 low-frequency |
| flash_req | input | 1 | Flash read or write request |
| pwr_en | output | 1 | Supply enable for the flash control circuit |
| wu_done | output | 1 | Warm-up complete status flag |
| access_ok | output | 1 | Flash access allowed |
| req_violation | output | 1 | Pulse for a request made while access is not allowed |

## Verification
A wrong count or a wrong latched tick source shows up as `wu_done` and `access_ok` rising too early or too late. The error is visible in the cycle after the final tick, so the bench checks the flag both one tick before and exactly at the expected length, for both sources. A state machine stuck in the wrong state shows at `pwr_en` on the cycle after a write, and as a wrong `req_violation` on the cycle after any request. The bench compares every output on every cycle against a cycle model, so each such error is caught within one cycle of its first effect.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
   typedef enum logic [1:0] {
      PS_OFF   = 2'd0,
      PS_WARM  = 2'd1,
      PS_READY = 2'd2
   } pwr_state_e;
endpackage

// File: rtl/fpw_ctrl.sv
module fpw_ctrl
   import fpw_pkg::*;
#(
   parameter bit BOOT_READY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic       cfg_wdata,
   input  logic       expire,
   output pwr_state_e state,
   output logic       start
);
   localparam pwr_state_e RST_STATE = BOOT_READY ? PS_READY : PS_OFF;

   pwr_state_e state_q, state_d;
   logic       clr_req;

   assign clr_req = cfg_wr & ~cfg_wdata;
   assign start   = cfg_wr & cfg_wdata & (state_q == PS_OFF);

   always_comb begin
      state_d = state_q;
      if (clr_req) begin
         state_d = PS_OFF;
      end else if (start) begin
         state_d = PS_WARM;
      end else if (state_q == PS_WARM && expire) begin
         state_d = PS_READY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RST_STATE;
      else        state_q <= state_d;
   end

   assign state = state_q;

   // R2 and R11: a clear always wins, whatever else happens in that cycle
   assert_clear_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (state_q == PS_OFF));

   // R3: a start always lands in the warm-up state
   assert_start_warm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (state_q == PS_WARM));

   // R4: the ready state is entered only from a finished count
   assert_ready_after_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == PS_READY) |-> $past(expire));

   // R7: a write of one while powered never turns the supply off or restarts
   assert_rewrite_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata && state_q == PS_READY) |=> (state_q == PS_READY));
endmodule

// File: rtl/fpw_timer.sv
module fpw_timer #(
   parameter int FAST_LOG2 = 10,
   parameter int SLOW_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic clk_sel,
   input  logic tick_fast,
   input  logic tick_slow,
   output logic expire
);
   localparam int MAXL = (FAST_LOG2 > SLOW_LOG2) ? FAST_LOG2 : SLOW_LOG2;
   localparam logic [MAXL-1:0] FAST_LAST = MAXL'((64'd1 << FAST_LOG2) - 64'd1);
   localparam logic [MAXL-1:0] SLOW_LAST = MAXL'((64'd1 << SLOW_LOG2) - 64'd1);

   generate
      if (FAST_LOG2 < 1 || FAST_LOG2 > 30) begin : g_bad_fast
         $error("FAST_LOG2 must lie in 1..30");
      end
      if (SLOW_LOG2 < 1 || SLOW_LOG2 > 30) begin : g_bad_slow
         $error("SLOW_LOG2 must lie in 1..30");
      end
   endgenerate

   logic            sel_q;
   logic [MAXL-1:0] cnt_q;
   logic [MAXL-1:0] last_val;
   logic            tick_sel;

   generate
      if (FAST_LOG2 == SLOW_LOG2) begin : g_one_len
         assign last_val = FAST_LAST;
      end else begin : g_two_len
         assign last_val = sel_q ? SLOW_LAST : FAST_LAST;
      end
   endgenerate

   assign tick_sel = sel_q ? tick_slow : tick_fast;
   assign expire   = run & tick_sel & (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         sel_q <= clk_sel;
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick_sel) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4 and R5: the count never passes the selected length
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= last_val));

   // R6: the tick source is frozen for the whole warm-up
   assert_sel_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && $past(run)) |-> $stable(sel_q));

   // R8: an idle timer holds zero, so an aborted count cannot carry over
   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> (cnt_q == '0));
endmodule

// File: rtl/fpw_guard.sv
module fpw_guard #(
   parameter bit VIOL_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic settled,
   input  logic flash_req,
   output logic access_ok,
   output logic req_violation
);
   logic bad_req;

   assign access_ok = pwr_on & settled;
   assign bad_req   = flash_req & ~access_ok;

   generate
      if (VIOL_REG) begin : g_reg
         logic viol_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) viol_q <= 1'b0;
            else        viol_q <= bad_req;
         end
         assign req_violation = viol_q;

         // R10: a pulse is always traced to a blocked request one cycle earlier
         assert_viol_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            req_violation |-> $past(flash_req && !access_ok));
      end else begin : g_comb
         assign req_violation = bad_req;
      end
   endgenerate

   // R9: the grant is never given to an unpowered circuit
   assert_grant_powered_R9: assert property (@(posedge clk) disable iff (!rst_n)
      access_ok |-> pwr_on);
endmodule

// File: rtl/flash_pwr_warmup.sv
module flash_pwr_warmup
   import fpw_pkg::*;
#(
   parameter int FAST_LOG2  = 10,
   parameter int SLOW_LOG2  = 3,
   parameter bit BOOT_READY = 1'b1,
   parameter bit VIOL_REG   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_wdata,
   input  logic tick_fast,
   input  logic tick_slow,
   input  logic clk_sel,
   input  logic flash_req,
   output logic pwr_en,
   output logic wu_done,
   output logic access_ok,
   output logic req_violation
);
   pwr_state_e state;
   logic       start;
   logic       expire;
   logic       run;

   fpw_ctrl #(.BOOT_READY(BOOT_READY)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .expire    (expire),
      .state     (state),
      .start     (start)
   );

   assign run = (state == PS_WARM);

   fpw_timer #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .run       (run),
      .clk_sel   (clk_sel),
      .tick_fast (tick_fast),
      .tick_slow (tick_slow),
      .expire    (expire)
   );

   assign pwr_en  = (state != PS_OFF);
   assign wu_done = (state == PS_READY);

   fpw_guard #(.VIOL_REG(VIOL_REG)) u_guard (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwr_on        (pwr_en),
      .settled       (wu_done),
      .flash_req     (flash_req),
      .access_ok     (access_ok),
      .req_violation (req_violation)
   );

   // R3: a fresh start always hides the ready flag
   assert_start_hides_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (pwr_en && !wu_done));
endmodule

// File: tb/sim_flash_pwr_warmup.sv
module sim_flash_pwr_warmup;
   localparam int CLK_PERIOD = 10;
   localparam int FAST_LEN   = 1024;
   localparam int SLOW_LEN   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_wdata = 1'b0;
   logic tick_fast = 1'b0, tick_slow = 1'b0, clk_sel = 1'b0, flash_req = 1'b0;
   logic pwr_en, wu_done, access_ok, req_violation;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // bench model: 0 off, 1 warming, 2 ready
   int m_state = 2;
   int m_cnt   = 0;
   bit m_sel   = 1'b0;
   bit m_viol  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_pwr_warmup u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .tick_fast(tick_fast), .tick_slow(tick_slow), .clk_sel(clk_sel),
      .flash_req(flash_req), .pwr_en(pwr_en), .wu_done(wu_done),
      .access_ok(access_ok), .req_violation(req_violation)
   );

   function automatic int warm_len(bit sel);
      return sel ? SLOW_LEN : FAST_LEN;
   endfunction

   task automatic expect_bit(string tag, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_model(string tag);
      expect_bit(tag, "pwr_en", pwr_en, m_state != 0);
      expect_bit(tag, "wu_done", wu_done, m_state == 2);
      expect_bit(tag, "access_ok", access_ok, m_state == 2);
      expect_bit(tag, "req_violation", req_violation, m_viol);
   endtask

   task automatic model_step(bit w, bit wd, bit tf, bit ts, bit sel, bit rq);
      m_viol = rq && (m_state != 2);
      if (w && !wd) begin
         m_state = 0; m_cnt = 0;
      end else if (w && wd && m_state == 0) begin
         m_state = 1; m_cnt = 0; m_sel = sel;
      end else if (m_state == 1 && (m_sel ? ts : tf)) begin
         if (m_cnt == warm_len(m_sel) - 1) m_state = 2;
         else m_cnt++;
      end
   endtask

   // drive after a falling edge, model at the rising edge, compare at the next falling edge
   task automatic cyc(bit w, bit wd, bit tf, bit ts, bit sel, bit rq, string tag);
      cfg_wr = w; cfg_wdata = wd; tick_fast = tf; tick_slow = ts;
      clk_sel = sel; flash_req = rq;
      @(posedge clk);
      model_step(w, wd, tf, ts, sel, rq);
      @(negedge clk);
      check_model(tag);
   endtask

   task automatic ticks(int n, bit tf, bit ts, bit sel, string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, tf, ts, sel, 1'b0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: boot state
      expect_bit("R1", "pwr_en", pwr_en, 1'b1);
      expect_bit("R1", "wu_done", wu_done, 1'b1);
      expect_bit("R1", "access_ok", access_ok, 1'b1);
      expect_bit("R1", "req_violation", req_violation, 1'b0);

      // R7: writing one while ready changes nothing
      cyc(1, 1, 0, 0, 0, 0, "R7");
      expect_bit("R7", "wu_done", wu_done, 1'b1);

      // R2: clear
      cyc(1, 0, 0, 0, 0, 0, "R2");
      expect_bit("R2", "pwr_en", pwr_en, 1'b0);
      expect_bit("R9", "access_ok", access_ok, 1'b0);

      // R10: request while off
      cyc(0, 0, 0, 0, 0, 1, "R10");
      expect_bit("R10", "req_violation", req_violation, 1'b1);
      cyc(0, 0, 0, 0, 0, 0, "R10");
      expect_bit("R10", "req_violation", req_violation, 1'b0);

      // R3: start on the fast source
      cyc(1, 1, 1, 1, 0, 0, "R3");
      expect_bit("R3", "pwr_en", pwr_en, 1'b1);
      expect_bit("R3", "wu_done", wu_done, 1'b0);

      // R4 with R6 and R7 in the middle: select flips, a second start write comes
      ticks(500, 1, 1, 0, "R4");
      cyc(1, 1, 1, 1, 1, 0, "R7");
      ticks(522, 1, 1, 1, "R6");
      expect_bit("R4", "wu_done one tick early", wu_done, 1'b0);
      cyc(0, 0, 1, 0, 1, 0, "R4");
      expect_bit("R4", "wu_done at length", wu_done, 1'b1);
      expect_bit("R9", "access_ok", access_ok, 1'b1);

      // R5: slow source, fast ticks ignored
      cyc(1, 0, 0, 0, 0, 0, "R2");
      cyc(1, 1, 0, 0, 1, 0, "R3");
      ticks(7, 1, 1, 1, "R5");
      expect_bit("R5", "wu_done one tick early", wu_done, 1'b0);
      ticks(20, 1, 0, 0, "R5");
      expect_bit("R5", "fast ticks ignored", wu_done, 1'b0);
      // R11: clear on the final tick wins
      cyc(1, 0, 0, 1, 1, 0, "R11");
      expect_bit("R11", "pwr_en", pwr_en, 1'b0);
      expect_bit("R11", "wu_done", wu_done, 1'b0);

      // R8: abort mid-count, then the full length is needed again
      cyc(1, 1, 0, 0, 1, 0, "R3");
      ticks(5, 0, 1, 1, "R8");
      cyc(1, 0, 0, 1, 1, 0, "R8");
      cyc(1, 1, 0, 0, 1, 0, "R8");
      ticks(7, 0, 1, 0, "R8");
      expect_bit("R8", "wu_done after restart, one early", wu_done, 1'b0);
      ticks(1, 0, 1, 0, "R8");
      expect_bit("R8", "wu_done after restart", wu_done, 1'b1);

      // random traffic against the model
      for (int i = 0; i < 6000; i++) begin
         bit w;
         w = ($urandom % 40) == 0;
         cyc(w, $urandom % 3 != 0, $urandom % 2, $urandom % 3 == 0,
             $urandom % 2, $urandom % 4 == 0, "R9");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule